// File: doc/BRIEF.md
# Shared Serial EEPROM Access Arbiter

This block lets a network controller borrow a serial EEPROM that another bus master also uses. A pulse on `start_i` raises a request line toward an external arbiter. The block then polls the grant line. Every poll begins with a one-cycle pulse that forces the EEPROM interface idle, and the grant is sampled in the cycle that follows. After a bounded number of polls without a grant, the attempt ends with a timeout.

When the grant arrives, the block hands a multi-word read to an EEPROM word-reader. By default the read starts at word 8 and covers 3 words of 16 bits. The block collects the words into a 48-bit station address. At the end of the access, whether it succeeded or timed out, the block first parks the EEPROM clock high. It then asserts done and drops the request, which returns the bus to the other master.

A one-cycle completion pulse reports the result, with either a success flag or a timeout flag. The serial bit protocol itself belongs to the word-reader and is not part of this block.

Top module: `ee_share_arb`

## Requirements
- R1: While reset is held and after it is released, `req_o`, `done_o`, `ee_idle_o`, `ee_clk_hi_o`, `rd_cmd_o`, `cmpl_o`, `ok_o` and `timeout_o` are 0, and `station_o` is 0.
- R2: A `start_i` pulse seen in idle sets `req_o` high from the next cycle and clears `done_o`, `ee_clk_hi_o`, the result flags and `station_o`. `req_o` stays high until the cycle before the completion cycle, and it falls only in the completion cycle.
- R3: Each grant check is preceded by exactly one cycle of `ee_idle_o`. `gnt_i` is sampled only in the cycle right after that pulse. At most MAX_POLLS idle pulses occur per access.
- R4: If `gnt_i` is low on all MAX_POLLS checks, no read command is issued. Counting the first cycle after the start edge as cycle 0, completion falls in cycle 2*MAX_POLLS+1, with `timeout_o`=1, `ok_o`=0 and `station_o`=0.
- R5: If the grant is first seen on check n (n counted from 1), `rd_cmd_o` rises in cycle 2n with `rd_addr_o`=8 and `rd_cnt_o`=3. It stays high through every cycle in which `rd_busy_i` is high and falls after the first cycle in which `rd_busy_i` is low.
- R6: Words that arrive on `rd_valid_i` after the command is accepted fill `station_o` in order: the first word goes to bits 15:0, the second to 31:16 and the third to 47:32. The cycle after the third word is the park cycle.
- R7: The park cycle shows `ee_clk_hi_o`=1 with `req_o` still 1 and `done_o`=0. The next cycle is the completion cycle, with `done_o`=1 and `req_o`=0. `ee_clk_hi_o` and `done_o` then stay high until the next accepted start.
- R8: `cmpl_o` is a one-cycle pulse. In that cycle exactly one of `ok_o` and `timeout_o` is 1, and `ok_o` is 1 only after all three words have arrived.
- R9: `start_i` has no effect when the block is not idle, including in the completion cycle.
- R10: `rd_valid_i` has no effect before the read command has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| start_i | input | 1 | Begin one access when idle |
| req_o | output | 1 | Request to the external arbiter |
| done_o | output | 1 | Release indication to the external arbiter |
| gnt_i | input | 1 | Grant from the external arbiter |
| ee_idle_o | output | 1 | Force the EEPROM interface idle (one cycle per poll) |
| ee_clk_hi_o | output | 1 | Hold the EEPROM clock line high |
| rd_cmd_o | output | 1 | Read command to the word-reader |
| rd_addr_o | output | ADDR_W | First word address of the read |
| rd_cnt_o | output | CNT_W | Number of words to read |
| rd_busy_i | input | 1 | Word-reader cannot take a command |
| rd_valid_i | input | 1 | A read word is present on rd_data_i |
| rd_data_i | input | WORD_W | Read word |
| cmpl_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Access finished with all words read |
| timeout_o | output | 1 | Access gave up without a grant |
| station_o | output | WORD_W*NUM_WORDS | Assembled station address |

## Verification
A controller that loses its place during polling shows up at once as a missing or doubled `ee_idle_o` pulse, and as a completion cycle that lands away from 2*MAX_POLLS+1 or 2n+busy+word-timing+5. A word index that has drifted puts a word into the wrong 16-bit slice of `station_o`, which the completion-cycle compare catches. A wrong release order is caught one cycle before `done_o` rises, because the park cycle must show the clock held high while the request is still up. Stray `rd_valid_i` and `start_i` pulses would change either the address image or the completion timing, so both are checked on every run.

// File: rtl/ee_share_pkg.sv
package ee_share_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_QUIET   = 3'd1,
        S_CHECK   = 3'd2,
        S_ISSUE   = 3'd3,
        S_COLLECT = 3'd4,
        S_PARK    = 3'd5,
        S_RELEASE = 3'd6
    } arb_state_e;

    typedef struct packed {
        arb_state_e st;
        logic       done;
        logic       park;
        logic       ok;
        logic       tmo;
    } arb_ctl_t;

endpackage

// File: rtl/ee_poll_ctr.sv
module ee_poll_ctr #(
    parameter int MAX_POLLS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/ee_word_collect.sv
module ee_word_collect #(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_i,
    input  logic                        valid_i,
    input  logic [WORD_W-1:0]           data_i,
    output logic                        last_o,
    output logic [WORD_W*NUM_WORDS-1:0] image_o
);
    localparam int IW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_WORDS - 1);

    logic [IW-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clr_i)
            idx_d = '0;
        else if (valid_i)
            idx_d = idx_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_q <= '0;
        else
            idx_q <= idx_d;
    end

    assign last_o = valid_i && (idx_q == LAST_IDX);

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slot
        logic [WORD_W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (clr_i)
                slot_d = '0;
            else if (valid_i && (idx_q == IW'(g)))
                slot_d = data_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q <= '0;
            else
                slot_q <= slot_d;
        end

        assign image_o[g*WORD_W +: WORD_W] = slot_q;
    end
endmodule

// File: rtl/ee_share_arb.sv
module ee_share_arb
    import ee_share_pkg::*;
#(
    parameter int MAX_POLLS = 1000,
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 3,
    parameter int BASE_ADDR = 8,
    parameter int ADDR_W    = 6,
    localparam int CNT_W    = $clog2(NUM_WORDS + 1),
    localparam int IMG_W    = WORD_W * NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              req_o,
    output logic              done_o,
    input  logic              gnt_i,
    output logic              ee_idle_o,
    output logic              ee_clk_hi_o,
    output logic              rd_cmd_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [CNT_W-1:0]  rd_cnt_o,
    input  logic              rd_busy_i,
    input  logic              rd_valid_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              cmpl_o,
    output logic              ok_o,
    output logic              timeout_o,
    output logic [IMG_W-1:0]  station_o
);
    arb_ctl_t ctl_d, ctl_q;
    logic     ctr_clr, ctr_inc, poll_last;
    logic     img_clr, word_vld, word_last;

    ee_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (ctr_clr),
        .inc_i  (ctr_inc),
        .last_o (poll_last)
    );

    // only words arriving after the command is accepted are stored
    assign word_vld = rd_valid_i && (ctl_q.st == S_COLLECT);

    ee_word_collect #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_words (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (img_clr),
        .valid_i (word_vld),
        .data_i  (rd_data_i),
        .last_o  (word_last),
        .image_o (station_o)
    );

    always_comb begin
        ctl_d   = ctl_q;
        ctr_clr = 1'b0;
        ctr_inc = 1'b0;
        img_clr = 1'b0;
        case (ctl_q.st)
            S_IDLE: begin
                if (start_i) begin
                    ctl_d.st   = S_QUIET;
                    ctl_d.done = 1'b0;
                    ctl_d.park = 1'b0;
                    ctl_d.ok   = 1'b0;
                    ctl_d.tmo  = 1'b0;
                    ctr_clr    = 1'b1;
                    img_clr    = 1'b1;
                end
            end
            S_QUIET: ctl_d.st = S_CHECK;
            S_CHECK: begin
                if (gnt_i) begin
                    ctl_d.st = S_ISSUE;
                end else if (poll_last) begin
                    ctl_d.st   = S_PARK;
                    ctl_d.park = 1'b1;
                    ctl_d.tmo  = 1'b1;
                end else begin
                    ctr_inc  = 1'b1;
                    ctl_d.st = S_QUIET;
                end
            end
            S_ISSUE: begin
                if (!rd_busy_i)
                    ctl_d.st = S_COLLECT;
            end
            S_COLLECT: begin
                if (word_last) begin
                    ctl_d.st   = S_PARK;
                    ctl_d.park = 1'b1;
                    ctl_d.ok   = 1'b1;
                end
            end
            S_PARK: begin
                ctl_d.st   = S_RELEASE;
                ctl_d.done = 1'b1;
            end
            S_RELEASE: ctl_d.st = S_IDLE;
            default:   ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl_q <= '{st: S_IDLE, done: 1'b0, park: 1'b0, ok: 1'b0, tmo: 1'b0};
        else
            ctl_q <= ctl_d;
    end

    assign req_o       = (ctl_q.st != S_IDLE) && (ctl_q.st != S_RELEASE);
    assign done_o      = ctl_q.done;
    assign ee_idle_o   = (ctl_q.st == S_QUIET);
    assign ee_clk_hi_o = ctl_q.park;
    assign rd_cmd_o    = (ctl_q.st == S_ISSUE);
    assign rd_addr_o   = ADDR_W'(BASE_ADDR);
    assign rd_cnt_o    = CNT_W'(NUM_WORDS);
    assign cmpl_o      = (ctl_q.st == S_RELEASE);
    assign ok_o        = ctl_q.ok;
    assign timeout_o   = ctl_q.tmo;
endmodule

// File: rtl/ee_share_arb_chk.sv
module ee_share_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic req_o,
    input logic done_o,
    input logic ee_idle_o,
    input logic ee_clk_hi_o,
    input logic rd_cmd_o,
    input logic rd_busy_i,
    input logic cmpl_o,
    input logic ok_o,
    input logic timeout_o
);
    a_r2_req_falls_at_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_o) |-> cmpl_o);

    a_r3_idle_single: assert property (@(posedge clk) disable iff (!rst_n)
        ee_idle_o |=> !ee_idle_o);

    a_r4_no_cmd_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !rd_cmd_o);

    a_r5_cmd_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd_o && rd_busy_i) |=> rd_cmd_o);

    a_r5_cmd_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd_o && !rd_busy_i) |=> !rd_cmd_o);

    a_r7_park_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(ee_clk_hi_o) && $past(req_o)));

    a_r8_cmpl_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_o |=> !cmpl_o);

    a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_o |-> (ok_o ^ timeout_o));
endmodule

bind ee_share_arb ee_share_arb_chk u_chk (.*);

// File: tb/ee_share_arb_tb.sv
module ee_share_arb_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_P      = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        gnt_i = 1'b0;
    logic        rd_busy_i = 1'b0;
    logic        rd_valid_i = 1'b0;
    logic [15:0] rd_data_i = '0;
    logic        req_o, done_o, ee_idle_o, ee_clk_hi_o, rd_cmd_o;
    logic [5:0]  rd_addr_o;
    logic [1:0]  rd_cnt_o;
    logic        cmpl_o, ok_o, timeout_o;
    logic [47:0] station_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ee_share_arb #(.MAX_POLLS(MAX_P)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_o(req_o), .done_o(done_o),
        .gnt_i(gnt_i), .ee_idle_o(ee_idle_o), .ee_clk_hi_o(ee_clk_hi_o),
        .rd_cmd_o(rd_cmd_o), .rd_addr_o(rd_addr_o), .rd_cnt_o(rd_cnt_o),
        .rd_busy_i(rd_busy_i), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .cmpl_o(cmpl_o), .ok_o(ok_o), .timeout_o(timeout_o), .station_o(station_o)
    );

    task automatic chk(input bit good, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // d: check number on which grant appears (d > MAX_P means never)
    // b: busy cycles before the command is taken; gap: idle cycles before each word
    task automatic run(input int d, input int b, input int gap, input bit noise,
                       input logic [47:0] img);
        int idles = 0, cyc = 0, busy_left = b, wi = 0, gapc = 0, exp_rel;
        bit acc = 0, in_wait = 0, seen_cmd = 0, fin = 0, prev_park = 0;
        bit exp_to = (d > MAX_P);
        exp_rel = exp_to ? 2*MAX_P + 1 : 2*d + b + 3*gap + 5;
        gnt_i = 0; rd_busy_i = 0; rd_valid_i = 0;
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        chk(req_o && !done_o && !ee_clk_hi_o && station_o == 0, "R2", "state after start",
            {req_o, done_o, ee_clk_hi_o}, 3'b100);
        while (!fin && cyc < 400) begin
            start_i = 0;
            rd_valid_i = 0;
            in_wait = acc;
            if (cmpl_o) begin
                fin = 1;
                chk(cyc == exp_rel, "R4/R5", "completion cycle", cyc, exp_rel);
                chk(timeout_o == exp_to && ok_o == !exp_to, "R8", "result flags",
                    {ok_o, timeout_o}, {!exp_to, exp_to});
                chk(station_o == (exp_to ? 48'h0 : img), "R6", "station image",
                    station_o, exp_to ? 48'h0 : img);
                chk(done_o && !req_o && ee_clk_hi_o, "R7", "release outputs",
                    {done_o, req_o, ee_clk_hi_o}, 3'b101);
                chk(prev_park, "R7", "park cycle before release", prev_park, 1);
                chk(seen_cmd == !exp_to, "R4", "read command issued", seen_cmd, !exp_to);
                chk(idles == (exp_to ? MAX_P : d), "R3", "idle pulses", idles,
                    exp_to ? MAX_P : d);
                start_i = 1; // R9: ignored in the completion cycle
            end else begin
                if (ee_idle_o) begin
                    idles++;
                    gnt_i = (idles >= d);
                    if (noise) begin
                        rd_valid_i = 1; // R10: stray word before command
                        rd_data_i  = 16'hBAD0;
                    end
                end
                if (rd_cmd_o) begin
                    if (!seen_cmd)
                        chk(rd_addr_o == 8 && rd_cnt_o == 3 && cyc == 2*d, "R5",
                            "command fields/cycle", {rd_addr_o, rd_cnt_o, 8'(cyc)},
                            {6'd8, 2'd3, 8'(2*d)});
                    seen_cmd = 1;
                    if (busy_left > 0) begin
                        rd_busy_i = 1;
                        busy_left--;
                    end else begin
                        rd_busy_i = 0;
                        acc  = 1;
                        gapc = gap;
                    end
                end else if (in_wait) begin
                    rd_busy_i = (wi < 3);
                    if (gapc > 0) begin
                        gapc--;
                    end else if (wi < 3) begin
                        rd_valid_i = 1;
                        rd_data_i  = img[wi*16 +: 16];
                        wi++;
                        gapc = gap;
                        if (noise && wi == 1) start_i = 1; // R9
                    end
                end
                prev_park = ee_clk_hi_o && req_o && !done_o;
            end
            @(negedge clk);
            if (!fin) cyc++;
        end
        start_i = 0;
        rd_valid_i = 0;
        chk(fin, "R8", "completion seen", fin, 1);
        @(negedge clk);
        @(negedge clk);
        chk(done_o && ee_clk_hi_o && !req_o && !cmpl_o, "R7/R9", "held after release",
            {done_o, ee_clk_hi_o, req_o, cmpl_o}, 4'b1100);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3);
        chk({req_o, done_o, ee_idle_o, ee_clk_hi_o, rd_cmd_o, cmpl_o, ok_o, timeout_o} == 0
            && station_o == 0, "R1", "outputs in reset",
            {req_o, done_o, ee_idle_o, ee_clk_hi_o, rd_cmd_o, cmpl_o, ok_o, timeout_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk({req_o, done_o, ee_idle_o, ee_clk_hi_o, rd_cmd_o, cmpl_o} == 0, "R1",
            "outputs after reset", {req_o, done_o, ee_idle_o, ee_clk_hi_o, rd_cmd_o, cmpl_o}, 0);
        for (int d = 1; d <= MAX_P; d++)
            for (int b = 0; b <= 2; b++)
                for (int gap = 0; gap <= 1; gap++)
                    run(d, b, gap, (d + b + gap) % 2 == 1,
                        {16'(16'h1000 + d*16'h101), 16'(16'h2000 + b*16'h11 + gap),
                         16'(16'h8000 + d*16 + b*2 + gap)});
        run(MAX_P + 1, 0, 0, 0, 48'h0);
        run(MAX_P + 1, 0, 0, 1, 48'h0);
        run(1000, 1, 0, 1, 48'h0);
        run(2, 1, 1, 0, 48'hA5A5_5A5A_0F0F);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule